// File: doc/BRIEF.md
# Configurable 8-bit Serial Shift Interface

This block exchanges one 8-bit frame at a time with an external device over a synchronous serial link. A single 8-bit buffer holds the byte to send and, when the frame ends, the byte that was received. Shifting happens in place. A register port writes a mode word and writes or reads the buffer. A start strobe begins a frame. When the eighth bit has been taken in, a one-cycle completion interrupt fires.

The serial clock comes from one of three sources. The first is an internal divider of the core clock with four rate settings. The second is a tick from a neighbouring timer/counter, where each tick makes one clock transition. The third is an external clock pin. With an internal or timer source the block drives the serial clock pin, and the pin rests high. With the external source the pin is only read: it passes through a two-flop synchronizer and its edges are detected. Output data changes on the falling serial edge and input data is sampled on the rising edge. Bit order and a receive-only mode are chosen in the mode word.

Top module: `ser8_xchg`

## Requirements
- R1: After reset, busy, irq and buf_rdata are 0, sdo and sck_o are 1, sck_oe is 1, and the mode word is 0 (internal source, full duplex, MSB first, rate 0).
- R2: A buffer write while idle loads buf_wdata into the buffer. A buffer write while busy is ignored, so the byte being sent is not disturbed.
- R3: A start pulse while idle raises busy and runs one frame of exactly 8 bits. A start pulse while busy is ignored and causes no second frame.
- R4: With mode bit 3 at 0 (MSB first), buffer bit 7 is sent first. The first received bit ends up in bit 7 of the buffer.
- R5: With mode bit 3 at 1 (LSB first), buffer bit 0 is sent first. The first received bit ends up in bit 0 of the buffer.
- R6: With mode bit 2 at 1 (receive only), sdo stays at 1 for the whole frame, and the received byte still lands in the buffer.
- R7: With mode bits 1:0 equal to 0 or 3 (internal source), the block drives the clock pin (sck_oe=1). Each clock half-period lasts 2^(rate+1) core cycles, where rate is mode bits 5:4. sck_o is high while idle.
- R8: With mode bits 1:0 equal to 2 (timer source), each tmr_tick seen while busy makes exactly one sck_o transition, so a frame takes exactly 16 ticks.
- R9: With mode bits 1:0 equal to 1 (external source), sck_oe is 0. The frame is clocked by sck_i edges after a two-flop synchronizer.
- R10: irq is a one-cycle pulse. It is raised on the same clock edge that clears busy, after the eighth rising serial edge.
- R11: A mode write while busy is ignored. A mode write while idle takes effect.
- R12: A buffer write and a start pulse in the same idle cycle load the new byte, and that byte is the one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 6 | Mode word: [1:0] clock source, [2] receive only, [3] LSB first, [5:4] rate |
| buf_we | input | 1 | Buffer write strobe |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer contents |
| start | input | 1 | Frame start strobe |
| tmr_tick | input | 1 | Clock tick from the timer/counter |
| sck_i | input | 1 | Serial clock pin, input side |
| sck_o | output | 1 | Serial clock pin, output side |
| sck_oe | output | 1 | Serial clock pin drive enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Frame completion pulse |

## Verification
The two register-side functions that can land in the same cycle are a buffer write and a start strobe. The bench provokes this twice. When idle, it raises both in one cycle, and it judges the result by the byte observed on sdo, which must be the newly written one. In the middle of a frame, it raises each on its own. There it judges by the sent bits, which must be unchanged, and by the irq count, which must be exactly one. A mode write in the middle of a frame is judged the same way: the bit order seen on sdo must stay as configured at start.

// File: rtl/ser8_pkg.sv
package ser8_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int RATE_W = 2;
    localparam int PRE_W  = 1 << RATE_W;

    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_EXT = 2'd1,
        SRC_TMR = 2'd2,
        SRC_ALT = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              lsb_first;
        logic              rx_only;
        clk_src_e          src;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef struct packed {
        logic fall;
        logic rise;
    } sck_evt_t;

    function automatic logic [DATA_W-1:0] shift_in(
        input logic [DATA_W-1:0] cur,
        input logic              b,
        input logic              lsb
    );
        return lsb ? {b, cur[DATA_W-1:1]} : {cur[DATA_W-2:0], b};
    endfunction

    function automatic logic out_bit(
        input logic [DATA_W-1:0] cur,
        input logic              lsb
    );
        return lsb ? cur[0] : cur[DATA_W-1];
    endfunction

endpackage

// File: rtl/ser8_clkgen.sv
module ser8_clkgen
    import ser8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  clk_src_e          src,
    input  logic [RATE_W-1:0] rate,
    input  logic              tmr_tick,
    input  logic              sck_pin,
    output logic              sck_o,
    output logic              sck_oe,
    output sck_evt_t          evt
);

    localparam int SYNC_N = 3;

    logic [PRE_W-1:0]  div_q;
    logic [PRE_W-1:0]  term;
    logic              sck_q;
    logic              ext;
    logic              gen_tick;
    logic [SYNC_N-1:0] sync_q;
    logic              ext_fall;
    logic              ext_rise;

    always_comb begin
        ext  = (src == SRC_EXT);
        term = (PRE_W'(1) << (32'(rate) + 1)) - PRE_W'(1);
        if (ext)
            gen_tick = 1'b0;
        else if (src == SRC_TMR)
            gen_tick = run & tmr_tick;
        else
            gen_tick = run & (div_q == term);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
            sck_q <= 1'b1;
        end else begin
            if (!ext && src != SRC_TMR)
                div_q <= (div_q == term) ? '0 : div_q + 1'b1;
            if (gen_tick)
                sck_q <= ~sck_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '1;
        else
            sync_q <= {sync_q[SYNC_N-2:0], sck_pin};
    end

    assign ext_fall = sync_q[SYNC_N-1] & ~sync_q[SYNC_N-2];
    assign ext_rise = ~sync_q[SYNC_N-1] & sync_q[SYNC_N-2];

    assign evt.fall = run & (ext ? ext_fall : (gen_tick & sck_q));
    assign evt.rise = run & (ext ? ext_rise : (gen_tick & ~sck_q));
    assign sck_o    = sck_q;
    assign sck_oe   = ~ext;

endmodule

// File: rtl/ser8_shift.sv
module ser8_shift
    import ser8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              buf_we,
    input  logic [DATA_W-1:0] buf_wdata,
    input  sck_evt_t          evt,
    input  logic              rx_only,
    input  logic              lsb_first,
    input  logic              sdi,
    output logic [DATA_W-1:0] sreg,
    output logic              busy,
    output logic              irq,
    output logic              sdo
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            irq   <= 1'b0;
            sdo   <= 1'b1;
        end else begin
            irq <= 1'b0;
            if (!busy) begin
                if (buf_we)
                    sreg <= buf_wdata;
                if (start) begin
                    busy  <= 1'b1;
                    cnt_q <= '0;
                    sdo   <= 1'b1;
                end
            end else begin
                if (evt.fall)
                    sdo <= rx_only ? 1'b1 : out_bit(sreg, lsb_first);
                if (evt.rise) begin
                    sreg  <= shift_in(sreg, sdi, lsb_first);
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        busy <= 1'b0;
                        irq  <= 1'b1;
                        sdo  <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ser8_xchg.sv
module ser8_xchg
    import ser8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              buf_we,
    input  logic [DATA_W-1:0] buf_wdata,
    output logic [DATA_W-1:0] buf_rdata,
    input  logic              start,
    input  logic              tmr_tick,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              busy,
    output logic              irq
);

    mode_t    mode_q;
    sck_evt_t evt;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (mode_we && !busy)
            mode_q <= mode_t'(mode_wdata);
    end

    ser8_clkgen u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .src      (mode_q.src),
        .rate     (mode_q.rate),
        .tmr_tick (tmr_tick),
        .sck_pin  (sck_i),
        .sck_o    (sck_o),
        .sck_oe   (sck_oe),
        .evt      (evt)
    );

    ser8_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .buf_we    (buf_we),
        .buf_wdata (buf_wdata),
        .evt       (evt),
        .rx_only   (mode_q.rx_only),
        .lsb_first (mode_q.lsb_first),
        .sdi       (sdi),
        .sreg      (buf_rdata),
        .busy      (busy),
        .irq       (irq),
        .sdo       (sdo)
    );

endmodule

// File: rtl/ser8_xchg_chk.sv
module ser8_xchg_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       irq,
    input logic       sdo,
    input logic       sck_o,
    input logic       sck_oe,
    input logic [5:0] mode_bits
);

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R10

    AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy); // R10

    AST_BUSY_END_IRQ: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq); // R10

    AST_RXONLY_SDO_HIGH: assert property (@(posedge clk) disable iff (rst)
        (busy && mode_bits[2]) |-> sdo); // R6

    AST_IDLE_SCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!busy && sck_oe) |-> sck_o); // R7

    AST_EXT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (mode_bits[1:0] == 2'd1) |-> !sck_oe); // R9

    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_bits)); // R11

endmodule

bind ser8_xchg ser8_xchg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .irq       (irq),
    .sdo       (sdo),
    .sck_o     (sck_o),
    .sck_oe    (sck_oe),
    .mode_bits (mode_q)
);

// File: tb/ser8_xchg_tb.sv
module ser8_xchg_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_we = 1'b0;
    logic [5:0] mode_wdata = '0;
    logic       buf_we = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic [7:0] buf_rdata;
    logic       start = 1'b0;
    logic       tmr_tick = 1'b0;
    logic       sck_i = 1'b1;
    logic       sck_o;
    logic       sck_oe;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       busy;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    logic [1:0] cur_src = 2'd0;
    logic       cur_rxo = 1'b0;
    logic       cur_lsb = 1'b0;
    logic [1:0] cur_rate = 2'd0;

    logic [7:0] r_tx;
    int         r_irqs;
    int         r_gap;
    int         r_ticks;
    bit         r_sdo_bad;

    always #4 clk = ~clk;

    ser8_xchg u_dut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .start(start), .tmr_tick(tmr_tick), .sck_i(sck_i), .sck_o(sck_o),
        .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo), .busy(busy), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] src, input logic rxo, input logic lsb,
                            input logic [1:0] rate);
        @(negedge clk);
        mode_we = 1'b1;
        mode_wdata = {rate, lsb, rxo, src};
        @(negedge clk);
        mode_we = 1'b0;
        cur_src = src; cur_rxo = rxo; cur_lsb = lsb; cur_rate = rate;
    endtask

    task automatic load(input logic [7:0] v);
        @(negedge clk);
        buf_we = 1'b1; buf_wdata = v;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    // inject: 0 none, 1 buffer write, 2 start, 3 mode flip, all mid-frame
    task automatic xfer(input logic [7:0] rx, input bit load_too, input logic [7:0] load_v,
                        input int inject);
        int kin = 0;
        int kout = 0;
        int cyc = 0;
        int ecnt = 0;
        int etog = 0;
        int f1 = -1;
        int f2 = -1;
        logic prev = 1'b1;
        r_tx = '0; r_irqs = 0; r_gap = -1; r_ticks = 0; r_sdo_bad = 0;
        @(negedge clk);
        start = 1'b1;
        if (load_too) begin buf_we = 1'b1; buf_wdata = load_v; end
        @(negedge clk);
        start = 1'b0; buf_we = 1'b0;
        while (cyc < 4000) begin
            @(negedge clk);
            cyc++;
            tmr_tick = 1'b0; buf_we = 1'b0; start = 1'b0; mode_we = 1'b0;
            if (irq) r_irqs++;
            if (busy && cur_rxo && sdo !== 1'b1) r_sdo_bad = 1;
            if (!busy) break;
            if (cur_src == 2'd1) begin
                ecnt++;
                if (ecnt == 8 && etog < 16) begin
                    ecnt = 0; etog++;
                    if (sck_i) begin
                        sck_i = 1'b0;
                        sdi = rx[cur_lsb ? kin : 7 - kin]; kin++;
                    end else begin
                        r_tx[cur_lsb ? kout : 7 - kout] = sdo; kout++;
                        sck_i = 1'b1;
                    end
                end
            end else begin
                if (sck_o !== prev) begin
                    if (!sck_o) begin
                        if (kout < 8) begin r_tx[cur_lsb ? kout : 7 - kout] = sdo; kout++; end
                        if (kin < 8) begin sdi = rx[cur_lsb ? kin : 7 - kin]; kin++; end
                        if (f1 < 0) f1 = cyc; else if (f2 < 0) f2 = cyc;
                    end
                    prev = sck_o;
                end
                if (cur_src == 2'd2 && (cyc % 3) == 0) begin
                    tmr_tick = 1'b1; r_ticks++;
                end
            end
            if (cyc == 20) begin
                if (inject == 1) begin buf_we = 1'b1; buf_wdata = 8'hFF; end
                if (inject == 2) start = 1'b1;
                if (inject == 3) begin
                    mode_we = 1'b1;
                    mode_wdata = {cur_rate, ~cur_lsb, cur_rxo, cur_src};
                end
            end
        end
        tmr_tick = 1'b0; buf_we = 1'b0; start = 1'b0; mode_we = 1'b0;
        repeat (3) begin
            @(negedge clk);
            if (irq) r_irqs++;
        end
        if (f1 >= 0 && f2 >= 0) r_gap = f2 - f1;
    endtask

    task automatic t_reset;
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(sdo == 1'b1 && sck_o == 1'b1, "R1 sdo/sck", {sdo, sck_o}, 3);
        check(sck_oe == 1'b1, "R1 sck_oe", sck_oe, 1);
        check(buf_rdata == 8'h00, "R1 buf", buf_rdata, 0);
    endtask

    task automatic t_msb;
        set_mode(2'd0, 1'b0, 1'b0, 2'd0);
        load(8'hA5);
        check(buf_rdata == 8'hA5, "R2 idle load", buf_rdata, 8'hA5);
        xfer(8'h3C, 0, 8'h00, 0);
        check(r_tx == 8'hA5, "R4 msb tx", r_tx, 8'hA5);
        check(buf_rdata == 8'h3C, "R4 msb rx", buf_rdata, 8'h3C);
        check(r_irqs == 1, "R10 one irq", r_irqs, 1);
        check(r_gap == 4, "R7 rate0 period", r_gap, 4);
        check(busy == 1'b0 && sck_o == 1'b1 && sdo == 1'b1, "R7 idle high",
              {busy, sck_o, sdo}, 3);
    endtask

    task automatic t_lsb;
        set_mode(2'd3, 1'b0, 1'b1, 2'd2);
        load(8'h96);
        xfer(8'h51, 0, 8'h00, 0);
        check(r_tx == 8'h96, "R5 lsb tx", r_tx, 8'h96);
        check(buf_rdata == 8'h51, "R5 lsb rx", buf_rdata, 8'h51);
        check(r_gap == 16, "R7 rate2 period", r_gap, 16);
    endtask

    task automatic t_rxonly;
        set_mode(2'd0, 1'b1, 1'b0, 2'd1);
        load(8'h00);
        xfer(8'hC3, 0, 8'h00, 0);
        check(r_sdo_bad == 0, "R6 sdo high", r_sdo_bad, 0);
        check(buf_rdata == 8'hC3, "R6 rx byte", buf_rdata, 8'hC3);
    endtask

    task automatic t_timer;
        set_mode(2'd2, 1'b0, 1'b0, 2'd0);
        load(8'h5A);
        xfer(8'hA6, 0, 8'h00, 0);
        check(r_ticks == 16, "R8 ticks per frame", r_ticks, 16);
        check(r_tx == 8'h5A, "R8 timer tx", r_tx, 8'h5A);
        check(buf_rdata == 8'hA6, "R8 timer rx", buf_rdata, 8'hA6);
    endtask

    task automatic t_ext;
        set_mode(2'd1, 1'b0, 1'b1, 2'd0);
        @(negedge clk);
        check(sck_oe == 1'b0, "R9 pin released", sck_oe, 0);
        load(8'h81);
        xfer(8'h7E, 0, 8'h00, 0);
        check(r_tx == 8'h81, "R9 ext tx", r_tx, 8'h81);
        check(buf_rdata == 8'h7E, "R9 ext rx", buf_rdata, 8'h7E);
        check(r_irqs == 1, "R10 ext irq", r_irqs, 1);
    endtask

    task automatic t_wr_busy;
        set_mode(2'd0, 1'b0, 1'b0, 2'd1);
        load(8'h33);
        xfer(8'hE1, 0, 8'h00, 1);
        check(r_tx == 8'h33, "R2 busy write ignored", r_tx, 8'h33);
        check(buf_rdata == 8'hE1, "R2 rx after busy write", buf_rdata, 8'hE1);
    endtask

    task automatic t_start_busy;
        load(8'h0F);
        xfer(8'h99, 0, 8'h00, 2);
        check(r_irqs == 1, "R3 busy start ignored", r_irqs, 1);
        check(busy == 1'b0, "R3 single frame", busy, 0);
        check(buf_rdata == 8'h99, "R3 rx", buf_rdata, 8'h99);
    endtask

    task automatic t_mode_busy;
        load(8'hC8);
        xfer(8'h1D, 0, 8'h00, 3);
        check(r_tx == 8'hC8, "R11 busy mode ignored tx", r_tx, 8'hC8);
        check(buf_rdata == 8'h1D, "R11 busy mode ignored rx", buf_rdata, 8'h1D);
    endtask

    task automatic t_same_cycle;
        load(8'h11);
        xfer(8'h42, 1, 8'hB7, 0);
        check(r_tx == 8'hB7, "R12 write with start", r_tx, 8'hB7);
        check(buf_rdata == 8'h42, "R12 rx", buf_rdata, 8'h42);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_msb();
        t_lsb();
        t_rxonly();
        t_timer();
        t_ext();
        t_wr_busy();
        t_start_busy();
        t_mode_busy();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule